// File: doc/BRIEF.md
# Serial MSB-First Magnitude Comparator

This block decides whether one unsigned number is larger than another when both arrive one bit per clock on two serial lines, most significant bit first. Because the high bits come first, the first bit position where the two operands differ settles the answer for good. Every lower bit that follows has no influence on it. The block keeps only a small memory of how the comparison stands: still tied, already known A greater, or already known A smaller.

An enable line frames each word. While enable is high, one bit pair is consumed on every rising clock edge. A clock edge that sees enable low throws away the verdict, so the next word starts fresh. The single output is taken directly from a state flip-flop. It reads 1 only once the machine has settled on A greater than B, and it can never follow the serial inputs combinationally.

Top module: `serial_mag_cmp`

## Requirements
- R1: A clock edge with `rst_n` low puts the machine in the tied state (code 00), so `gt_out` reads 0 after that edge, whatever the other inputs are.
- R2: A clock edge with `en` low returns the machine to the tied state, so `gt_out` reads 0 after that edge, whatever `a_bit` and `b_bit` are.
- R3: From the tied state, an edge with `en`=1, `a_bit`=1 and `b_bit`=0 moves the machine to the A-greater state (code 10), and `gt_out` reads 1 after that same edge.
- R4: From the tied state, an edge with `en`=1, `a_bit`=0 and `b_bit`=1 moves the machine to the A-smaller state (code 01). `gt_out` stays 0 there, and later bit pairs in the same word cannot raise it.
- R5: From the tied state, an edge with `en`=1 and equal bits (00 or 11) leaves the machine tied, with `gt_out` at 0.
- R6: Once the machine is in either decided state, it keeps that state for any `a_bit`/`b_bit` values for as long as `en` stays high.
- R7: `gt_out` is a registered Moore output. Changing `a_bit` or `b_bit` between clock edges does not change it.
- R8: For a word of 1 to 16 bits fed MSB first, `gt_out` after the edge that samples bit i equals the unsigned comparison of the two operand prefixes seen so far. After the last bit, it therefore equals A > B.
- R9: After at least one `en`-low cycle, a new word is judged without regard to the verdict of the previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | High while a word is being shifted in; low clears the verdict |
| a_bit | input | 1 | Serial bit of operand A, MSB first |
| b_bit | input | 1 | Serial bit of operand B, MSB first |
| gt_out | output | 1 | Registered flag, 1 once A is known to exceed B |

## Verification
The bench targets these corner cases:
- Words whose operands are equal. A design that let a tie fall into a verdict would report a false greater.
- Words where A loses early and then shows larger low bits. A design that did not lock the smaller verdict would flip `gt_out` to 1 late in the word.
- A greater verdict followed by a single enable-low cycle and a new word. A design that failed to clear would carry a stale 1 into that word.
- Mid-cycle toggling of the serial inputs, and a reset while a verdict is held. These expose an output decoded from the live inputs, or a reset that does not reach the state.

Random words of 1 to 16 bits, many built with equal operands or with a single flipped bit, are checked against prefix comparisons computed in the bench.

// File: rtl/scmp_pkg.sv
// Package: shared state encoding of the serial magnitude comparator.
// Assumes two state bits. The high bit doubles as the output flag, so the
// code for "A greater" must keep bit 1 set and all other used codes clear it.
package scmp_pkg;
    localparam int STATE_W = 2;
    localparam int GT_BIT  = STATE_W - 1;

    typedef enum logic [STATE_W-1:0] {
        CMP_TIE  = 2'b00,
        CMP_A_LT = 2'b01,
        CMP_A_GT = 2'b10,
        CMP_BAD  = 2'b11
    } cmp_state_e;
endpackage

// File: rtl/scmp_next.sv
// Module: next-state logic of the serial comparator (purely combinational).
// Assumes operands are MSB first, so the first unequal pair decides.
// A low enable and the unused code both steer back to the tied state.
module scmp_next
    import scmp_pkg::*;
(
    input  cmp_state_e cur,
    input  logic       en,
    input  logic       a_bit,
    input  logic       b_bit,
    output cmp_state_e nxt
);
    // Choose the following state from the current verdict and the bit pair.
    always_comb begin
        nxt = CMP_TIE;
        if (en) begin
            case (cur)
                CMP_TIE: begin
                    if (a_bit && !b_bit)      nxt = CMP_A_GT;
                    else if (!a_bit && b_bit) nxt = CMP_A_LT;
                    else                      nxt = CMP_TIE;
                end
                CMP_A_GT: nxt = CMP_A_GT;
                CMP_A_LT: nxt = CMP_A_LT;
                default:  nxt = CMP_TIE;
            endcase
        end
    end
endmodule

// File: rtl/scmp_state_reg.sv
// Module: state register of the serial comparator.
// Assumes a synchronous active-low reset that loads the tied state.
module scmp_state_reg
    import scmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmp_state_e d,
    output cmp_state_e q
);
    // Capture the next state on each rising edge, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= CMP_TIE;
        else        q <= d;
    end
endmodule

// File: rtl/serial_mag_cmp.sv
// Module: top of the serial MSB-first unsigned magnitude comparator.
// Assumes words are separated by at least one cycle with en low.
// gt_out is the high state flip-flop, so it never follows a_bit/b_bit directly.
module serial_mag_cmp
    import scmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic gt_out
);
    cmp_state_e state_q;
    cmp_state_e state_d;

    scmp_next u_next (
        .cur   (state_q),
        .en    (en),
        .a_bit (a_bit),
        .b_bit (b_bit),
        .nxt   (state_d)
    );

    scmp_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (state_d),
        .q     (state_q)
    );

    // Moore output: the high state bit is the greater flag.
    assign gt_out = state_q[GT_BIT];

    // Reset leaves the tied state.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == CMP_TIE));

    // The unused code never appears after reset.
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (state_q != CMP_BAD));

    // A low enable clears the verdict.
    assert_clear_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == CMP_TIE));

    // The first pair with A=1, B=0 decides for A.
    assert_first_gt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == CMP_TIE && a_bit && !b_bit) |=> (state_q == CMP_A_GT));

    // The first pair with A=0, B=1 decides for B.
    assert_first_lt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == CMP_TIE && !a_bit && b_bit) |=> (state_q == CMP_A_LT));

    // Equal bits keep the tie.
    assert_tie_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == CMP_TIE && (a_bit == b_bit)) |=> (state_q == CMP_TIE));

    // A decided verdict is held while enable stays high.
    assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (state_q == CMP_A_GT || state_q == CMP_A_LT)) |=> $stable(state_q));
endmodule

// File: tb/sim_serial_mag_cmp.sv
module sim_serial_mag_cmp;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 16;
    localparam int N_WORDS    = 400;

    logic clk = 1'b0;
    logic rst_n, en, a_bit, b_bit;
    logic gt_out;
    int   checks = 0;
    int   fails  = 0;

    serial_mag_cmp u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .a_bit  (a_bit),
        .b_bit  (b_bit),
        .gt_out (gt_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gt_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one bit pair, let one edge pass, and return a quarter period later.
    task automatic step(input logic r, input logic e, input logic a, input logic b);
        rst_n = r; en = e; a_bit = a; b_bit = b;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    // Unsigned comparison of the MSB-first prefix ending at bit position pos.
    function automatic logic prefix_gt(input logic [MAX_LEN-1:0] av,
                                       input logic [MAX_LEN-1:0] bv,
                                       input int len, input int pos);
        logic [MAX_LEN-1:0] mask;
        mask = (len == MAX_LEN) ? '1 : ((MAX_LEN'(1) << len) - 1'b1);
        return ((av & mask) >> pos) > ((bv & mask) >> pos);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run hung, gt_out=%0b expected completion", gt_out);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [MAX_LEN-1:0] av, bv;
        int len;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; en = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
        #(CLK_PERIOD/4);

        // R1: reset wins even with a deciding pair present.
        step(1'b0, 1'b1, 1'b1, 1'b0);
        check(gt_out, 1'b0, "R1 reset");
        step(1'b0, 1'b1, 1'b1, 1'b0);
        check(gt_out, 1'b0, "R1 reset held");

        // R5 then R3: ties stay low, first A>B pair raises the flag.
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check(gt_out, 1'b0, "R5 tie 00");
        step(1'b1, 1'b1, 1'b1, 1'b1);
        check(gt_out, 1'b0, "R5 tie 11");
        step(1'b1, 1'b1, 1'b1, 1'b0);
        check(gt_out, 1'b1, "R3 first greater");

        // R6: greater verdict held for all pairs.
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check(gt_out, 1'b1, "R6 hold after 01");
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check(gt_out, 1'b1, "R6 hold after 00");

        // R7: toggling the serial inputs between edges leaves the output alone.
        a_bit = 1'b0; b_bit = 1'b1;
        #1 check(gt_out, 1'b1, "R7 no comb path 01");
        a_bit = 1'b0; b_bit = 1'b0;
        #1 check(gt_out, 1'b1, "R7 no comb path 00");

        // R1: mid-run reset clears a held verdict.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        check(gt_out, 1'b0, "R1 mid-run reset");

        // R4: smaller verdict locks out later greater bits.
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check(gt_out, 1'b0, "R4 first smaller");
        step(1'b1, 1'b1, 1'b1, 1'b0);
        check(gt_out, 1'b0, "R4 locked smaller");
        // R7: the deciding-looking pair between edges changes nothing.
        a_bit = 1'b1; b_bit = 1'b0;
        #1 check(gt_out, 1'b0, "R7 no comb path 10");

        // R2 and R9: one idle cycle clears, next word judged fresh.
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check(gt_out, 1'b0, "R2 idle clears");
        step(1'b1, 1'b1, 1'b1, 1'b0);
        check(gt_out, 1'b1, "R9 fresh word greater");
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check(gt_out, 1'b0, "R2 idle clears greater");
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check(gt_out, 1'b0, "R9 fresh word smaller");
        step(1'b1, 1'b0, 1'b1, 1'b1);
        check(gt_out, 1'b0, "R2 idle");

        // R8: random words with per-bit prefix checks.
        for (int w = 0; w < N_WORDS; w++) begin
            len = 1 + int'($urandom_range(MAX_LEN - 1));
            av  = MAX_LEN'($urandom);
            case ($urandom_range(3))
                0:       bv = av;
                1:       bv = av ^ (MAX_LEN'(1) << $urandom_range(len - 1));
                default: bv = MAX_LEN'($urandom);
            endcase
            for (int i = len - 1; i >= 0; i--) begin
                step(1'b1, 1'b1, av[i], bv[i]);
                check(gt_out, prefix_gt(av, bv, len, i), "R8 prefix compare");
            end
            step(1'b1, 1'b0, 1'($urandom), 1'($urandom));
            check(gt_out, 1'b0, "R2 gap between words");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule